// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block collects 32 level-sensitive interrupt sources and presents two request lines to a processor: a normal request and a fast request. Both lines look at the same source levels. Each line has its own enable mask, so software can send any source to either line, to both, or to neither. A source stays pending for only as long as its input line is high. The controller does not latch edges, rank sources or produce vectors.

Software reaches the controller through a simple word-addressed 32-bit register bus. The masks are never written directly. Software writes a set word to turn enable bits on and a clear word to turn them off, so two agents can change different bits without a read-modify-write. Source 0 also has a software flop that can raise it, which lets firmware post an interrupt to itself. Both request lines, read data and the bus error flag are registered.

Top module: `dual_irq_mask_ctrl`

## Requirements
- R1: After a synchronous active-high reset, both enable masks and the software flop are zero, and `irq_o`, `fiq_o`, `bus_rdata` and `bus_err` are all low.
- R2: `irq_o` is high in a cycle exactly when, at the preceding clock edge, the bitwise AND of the level vector and the normal mask was nonzero. A mask write or a source change therefore shows up one clock later.
- R3: `fiq_o` follows the same rule using the fast mask. It is independent of the normal mask, and writes to one mask never alter the other.
- R4: A write to word 2 ORs `bus_wdata` into the normal mask. A write to word 10 ORs it into the fast mask. Bits written as zero keep their value.
- R5: A write to word 3 clears the normal-mask bits that are set in `bus_wdata`. A write to word 11 does the same for the fast mask. Other bits keep their value.
- R6: A write to word 4 with bit 0 set raises the software flop, and a write to word 5 with bit 0 set lowers it. Writes to words 4 and 5 with bit 0 clear leave the flop unchanged. Level bit 0 is input 0 ORed with the software flop.
- R7: A read returns its data on `bus_rdata` one clock after `bus_rd_en` is sampled. The words are mapped as follows:
  - word 0: masked normal status
  - words 1 and 9: raw level vector
  - word 2: normal mask
  - word 4: level bit 0 in bit 0, with the upper bits zero
  - word 8: masked fast status
  - word 10: fast mask
- R8: The following accesses are errors: reads of words 3, 5 and 11, writes to words 0, 1, 8 and 9, and any access to an unmapped word (6, 7, 12 and above). An erroneous read returns zero, and an erroneous write changes no state. In both cases `bus_err` is high in the same cycle that read data would appear. For every legal access, `bus_err` is low.
- R9: Each level bit other than bit 0 follows its input line with no latching. The bit reads as 1 while the input is high and as 0 once the input goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered access-error flag |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The sources are driven with several patterns: a single isolated bit, the all-zero vector, a sparse pattern spread over the upper half, and input 0 on its own. These patterns separate a correct AND-then-OR reduction from one that ignores the mask, or that checks only the lowest bit. The mask patterns overlap the active sources on one output and miss them on the other, which shows that the two masks are truly independent. Set and clear writes are made with mixed bit patterns, so an OR write can be told apart from an overwrite. Writes to the software words with bit 0 clear, and accesses to every class of illegal word, check that nothing changes there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned CH_NORMAL = 0;
    localparam int unsigned CH_FAST   = 1;
    localparam int unsigned NUM_CH    = 2;

    // Word indices whose meaning the bus decode depends on.
    localparam int unsigned WD_N_STAT  = 0;
    localparam int unsigned WD_RAW_A   = 1;
    localparam int unsigned WD_N_SET   = 2;
    localparam int unsigned WD_N_CLR   = 3;
    localparam int unsigned WD_SW_SET  = 4;
    localparam int unsigned WD_SW_CLR  = 5;
    localparam int unsigned WD_F_STAT  = 8;
    localparam int unsigned WD_RAW_B   = 9;
    localparam int unsigned WD_F_SET   = 10;
    localparam int unsigned WD_F_CLR   = 11;

    typedef struct packed {
        logic n_set;
        logic n_clr;
        logic f_set;
        logic f_clr;
        logic sw_set;
        logic sw_clr;
        logic bad;
    } wr_dec_t;

    typedef enum logic [2:0] {
        RS_N_STAT,
        RS_RAW,
        RS_N_MASK,
        RS_SW_BIT,
        RS_F_STAT,
        RS_F_MASK,
        RS_BAD
    } rd_sel_t;

    function automatic wr_dec_t decode_write(input int unsigned word);
        wr_dec_t d;
        d = '0;
        case (word)
            WD_N_SET:  d.n_set  = 1'b1;
            WD_N_CLR:  d.n_clr  = 1'b1;
            WD_F_SET:  d.f_set  = 1'b1;
            WD_F_CLR:  d.f_clr  = 1'b1;
            WD_SW_SET: d.sw_set = 1'b1;
            WD_SW_CLR: d.sw_clr = 1'b1;
            default:   d.bad    = 1'b1;
        endcase
        return d;
    endfunction

    function automatic rd_sel_t decode_read(input int unsigned word);
        rd_sel_t s;
        case (word)
            WD_N_STAT:          s = RS_N_STAT;
            WD_RAW_A, WD_RAW_B: s = RS_RAW;
            WD_N_SET:           s = RS_N_MASK;
            WD_SW_SET:          s = RS_SW_BIT;
            WD_F_STAT:          s = RS_F_STAT;
            WD_F_SET:           s = RS_F_MASK;
            default:            s = RS_BAD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  wr_dec_t                         dec,
    input  logic [NUM_SRC-1:0]              wdata,
    output logic [NUM_CH-1:0][NUM_SRC-1:0]  masks,
    output logic                            sw_q
);

    logic [NUM_CH-1:0] set_hit;
    logic [NUM_CH-1:0] clr_hit;

    always_comb begin
        set_hit            = '0;
        clr_hit            = '0;
        set_hit[CH_NORMAL] = wr_en & dec.n_set;
        clr_hit[CH_NORMAL] = wr_en & dec.n_clr;
        set_hit[CH_FAST]   = wr_en & dec.f_set;
        clr_hit[CH_FAST]   = wr_en & dec.f_clr;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                masks[c] <= '0;
            end else if (set_hit[c]) begin
                masks[c] <= masks[c] | wdata;
            end else if (clr_hit[c]) begin
                masks[c] <= masks[c] & ~wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= 1'b0;
        end else if (wr_en && dec.sw_set && wdata[0]) begin
            sw_q <= 1'b1;
        end else if (wr_en && dec.sw_clr && wdata[0]) begin
            sw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irqc_out_stage.sv
module irqc_out_stage
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SRC-1:0]              level,
    input  logic [NUM_CH-1:0][NUM_SRC-1:0]  masks,
    output logic [NUM_CH-1:0][NUM_SRC-1:0]  masked,
    output logic [NUM_CH-1:0]               req_q
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign masked[c] = level & masks[c];

        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[c] <= 1'b0;
            end else begin
                req_q[c] <= |masked[c];
            end
        end
    end

endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  rd_sel_t                         sel,
    input  logic                            wr_bad,
    input  logic [NUM_SRC-1:0]              level,
    input  logic [NUM_CH-1:0][NUM_SRC-1:0]  masks,
    input  logic [NUM_CH-1:0][NUM_SRC-1:0]  masked,
    output logic [NUM_SRC-1:0]              rdata,
    output logic                            err
);

    logic [NUM_SRC-1:0] mux;

    always_comb begin
        mux = '0;
        case (sel)
            RS_N_STAT: mux = masked[CH_NORMAL];
            RS_RAW:    mux = level;
            RS_N_MASK: mux = masks[CH_NORMAL];
            RS_SW_BIT: mux[0] = level[0];
            RS_F_STAT: mux = masked[CH_FAST];
            RS_F_MASK: mux = masks[CH_FAST];
            default:   mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_en ? mux : '0;
            err   <= (rd_en && sel == RS_BAD) || wr_bad;
        end
    end

endmodule

// File: rtl/dual_irq_mask_ctrl.sv
module dual_irq_mask_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               bus_err,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int unsigned SW_PAD = NUM_SRC - 1;

    wr_dec_t                        wdec;
    rd_sel_t                        rsel;
    logic [NUM_CH-1:0][NUM_SRC-1:0] masks;
    logic [NUM_CH-1:0][NUM_SRC-1:0] masked;
    logic [NUM_CH-1:0]              req_q;
    logic                           sw_q;
    logic [NUM_SRC-1:0]             level;
    logic [NUM_SRC-1:0]             irq_mask;
    logic [NUM_SRC-1:0]             fiq_mask;

    assign wdec     = decode_write(int'(bus_addr));
    assign rsel     = decode_read(int'(bus_addr));
    assign level    = src_i | {{SW_PAD{1'b0}}, sw_q};
    assign irq_mask = masks[CH_NORMAL];
    assign fiq_mask = masks[CH_FAST];

    irqc_mask_regs #(.NUM_SRC(NUM_SRC)) u_masks (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr_en),
        .dec   (wdec),
        .wdata (bus_wdata),
        .masks (masks),
        .sw_q  (sw_q)
    );

    irqc_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
        .clk    (clk),
        .rst    (rst),
        .level  (level),
        .masks  (masks),
        .masked (masked),
        .req_q  (req_q)
    );

    irqc_read_port #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (bus_rd_en),
        .sel    (rsel),
        .wr_bad (bus_wr_en & wdec.bad),
        .level  (level),
        .masks  (masks),
        .masked (masked),
        .rdata  (bus_rdata),
        .err    (bus_err)
    );

    assign irq_o = req_q[CH_NORMAL];
    assign fiq_o = req_q[CH_FAST];

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               bus_err,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] irq_mask,
    input logic [NUM_SRC-1:0] fiq_mask,
    input logic               sw_q
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq_o && !fiq_o && !bus_err && irq_mask == '0 && fiq_mask == '0));

    // R2
    a_r2_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(irq_mask != '0));

    // R3
    a_r3_fiq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> $past(fiq_mask != '0));

    // R4
    a_r4_set_keeps_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && int'(bus_addr) == 2)
        |=> ((irq_mask & $past(bus_wdata)) == $past(bus_wdata)) && $stable(fiq_mask));

    // R5
    a_r5_clear_drops_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && int'(bus_addr) == 11)
        |=> ((fiq_mask & $past(bus_wdata)) == '0) && $stable(irq_mask));

    // R8
    a_r8_bad_write_inert: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && !bus_rd_en && (int'(bus_addr) == 0 || int'(bus_addr) == 9))
        |=> ($stable(irq_mask) && $stable(fiq_mask) && $stable(sw_q) && bus_err));

    // R8
    a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && !bus_wr_en && int'(bus_addr) == 3)
        |=> (bus_rdata == '0 && bus_err));

endmodule

bind dual_irq_mask_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .irq_mask  (irq_mask),
    .fiq_mask  (fiq_mask),
    .sw_q      (sw_q)
);

// File: tb/dual_irq_mask_ctrl_bench.sv
module dual_irq_mask_ctrl_bench;

    localparam int KIND_RDATA = 0;
    localparam int KIND_ERR   = 1;
    localparam int KIND_IRQ   = 2;
    localparam int KIND_FIQ   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_o;
    logic        fiq_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          due_q[$];
    int          kind_q[$];
    logic [31:0] val_q[$];
    string       req_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    dual_irq_mask_ctrl u_dual_irq_mask_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic push(input int kind, input logic [31:0] val, input string req);
        due_q.push_back(cyc + 1);
        kind_q.push_back(kind);
        val_q.push_back(val);
        req_q.push_back(req);
    endtask

    // Monitor: compares each expected item once its cycle has come.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                logic [31:0] act;
                int          k;
                k = kind_q[0];
                case (k)
                    KIND_RDATA: act = bus_rdata;
                    KIND_ERR:   act = {31'd0, bus_err};
                    KIND_IRQ:   act = {31'd0, irq_o};
                    default:    act = {31'd0, fiq_o};
                endcase
                checks++;
                if (act !== val_q[0]) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", req_q[0], k, act, val_q[0]);
                end
                void'(due_q.pop_front());
                void'(kind_q.pop_front());
                void'(val_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    task automatic wr(input int word, input logic [31:0] data, input bit bad, input string req);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = 4'(word);
        bus_wdata = data;
        push(KIND_ERR, {31'd0, bad}, req);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input int word, input logic [31:0] exp, input bit bad, input string req);
        @(negedge clk);
        bus_rd_en = 1'b1;
        bus_addr  = 4'(word);
        push(KIND_RDATA, exp, req);
        push(KIND_ERR, {31'd0, bad}, req);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic pins(input bit irq, input bit fiq, input string req);
        @(negedge clk);
        push(KIND_IRQ, {31'd0, irq}, req);
        push(KIND_FIQ, {31'd0, fiq}, req);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        pins(1'b0, 1'b0, "R1 outputs after reset");
        rd(2, 32'h0, 1'b0, "R1 normal mask reset");
        rd(10, 32'h0, 1'b0, "R1 fast mask reset");
        rd(4, 32'h0, 1'b0, "R1 soft bit reset");

        // R9: raw level follows a single source
        src_i = 32'h0000_0100;
        rd(1, 32'h0000_0100, 1'b0, "R9 raw word1 single source");
        pins(1'b0, 1'b0, "R2 no mask no request");

        // R4 / R2 / R7
        wr(2, 32'h0000_0300, 1'b0, "R4 normal set");
        rd(2, 32'h0000_0300, 1'b0, "R4 normal mask readback");
        pins(1'b1, 1'b0, "R2 normal request masked in");
        rd(0, 32'h0000_0100, 1'b0, "R7 normal status");

        // R3 / R4: fast mask is independent and ORs
        wr(10, 32'h8000_0001, 1'b0, "R4 fast set");
        pins(1'b1, 1'b0, "R3 fast mask misses sources");
        rd(8, 32'h0, 1'b0, "R7 fast status empty");
        wr(10, 32'h0000_0100, 1'b0, "R4 fast set second");
        rd(10, 32'h8000_0101, 1'b0, "R4 fast mask OR accumulate");
        pins(1'b1, 1'b1, "R3 fast request");
        rd(8, 32'h0000_0100, 1'b0, "R7 fast status");

        // R5: clear normal bit, fast unchanged
        wr(3, 32'h0000_0100, 1'b0, "R5 normal clear");
        rd(2, 32'h0000_0200, 1'b0, "R5 normal mask after clear");
        pins(1'b0, 1'b1, "R3 fast kept after normal clear");

        // R9: source drops
        src_i = 32'h0;
        rd(9, 32'h0, 1'b0, "R9 raw word9 after drop");
        pins(1'b0, 1'b0, "R9 requests drop with source");

        // R6: software bit
        wr(4, 32'hFFFF_FFFE, 1'b0, "R6 soft set bit0 clear");
        rd(4, 32'h0, 1'b0, "R6 soft set ignored without bit0");
        wr(4, 32'h0000_0001, 1'b0, "R6 soft set");
        rd(4, 32'h1, 1'b0, "R6 soft readback");
        rd(1, 32'h1, 1'b0, "R6 raw shows soft bit");
        pins(1'b0, 1'b1, "R6 soft bit reaches fast");
        wr(5, 32'hFFFF_FFFE, 1'b0, "R6 soft clear bit0 clear");
        rd(4, 32'h1, 1'b0, "R6 soft clear ignored without bit0");
        wr(5, 32'h0000_0001, 1'b0, "R6 soft clear");
        rd(4, 32'h0, 1'b0, "R6 soft cleared");
        pins(1'b0, 1'b0, "R6 fast drops after soft clear");
        src_i = 32'h0000_0001;
        rd(4, 32'h1, 1'b0, "R6 input0 alone sets level bit0");
        src_i = 32'h0;

        // R8: illegal accesses
        rd(3, 32'h0, 1'b1, "R8 read word3");
        rd(5, 32'h0, 1'b1, "R8 read word5");
        rd(11, 32'h0, 1'b1, "R8 read word11");
        rd(6, 32'h0, 1'b1, "R8 read unmapped word6");
        wr(0, 32'hFFFF_FFFF, 1'b1, "R8 write word0");
        rd(2, 32'h0000_0200, 1'b0, "R8 normal mask untouched");
        wr(9, 32'hFFFF_FFFF, 1'b1, "R8 write word9");
        rd(10, 32'h8000_0101, 1'b0, "R8 fast mask untouched");
        wr(13, 32'hFFFF_FFFF, 1'b1, "R8 write unmapped word13");
        rd(4, 32'h0, 1'b0, "R8 soft bit untouched");

        // R5 fast clear all
        wr(11, 32'hFFFF_FFFF, 1'b0, "R5 fast clear all");
        rd(10, 32'h0, 1'b0, "R5 fast mask cleared");

        // R2: sparse upper-half sources
        src_i = 32'hA5A5_0000;
        wr(2, 32'h0000_FFFF, 1'b0, "R4 low half set");
        pins(1'b0, 1'b0, "R2 mask misses upper sources");
        wr(2, 32'h0001_0000, 1'b0, "R4 bit16 set");
        pins(1'b1, 1'b0, "R2 bit16 matches source");
        rd(0, 32'h0001_0000, 1'b0, "R7 normal status sparse");
        rd(9, 32'hA5A5_0000, 1'b0, "R9 raw sparse");

        while (due_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule